// File: doc/BRIEF.md
# Elapsed-Time Meter with Disconnect and End-of-Charge Timestamps

This block keeps a binary count of elapsed seconds for a battery pack. It advances the count by one on each one-second tick. The host reads the count through a holding copy. That copy is refreshed only when a snapshot strobe arrives, so a multi-byte read never shows bytes from two different seconds. The protocol logic raises the strobe once it has decoded a recall command.

Two timestamp words record the count at two moments. The first is when the bus line has been held low long enough to mean the pack was pulled out. The second is when charge current stops flowing into the pack. A pulled-out pack also raises a sleep indication, which tells the rest of the pack to stop everything except timekeeping. A strap input suppresses this indication for systems that keep measuring after removal. The host can overwrite the count and both timestamps one byte at a time. Byte 0 is always the least significant byte.

Top module: `pack_timekeeper`

## Requirements
- R1: After reset, the counter, the holding copy and both timestamps read as zero, and sleep is low.
- R2: Each cycle with `sec_tick` high, and no host write to the counter, adds one to the live count. The count wraps from all ones to zero, that is, modulo 2^CNT_W.
- R3: A host write with `wr_sel` = 0 replaces byte `wr_byte` of the live count at the next clock edge. Byte 0 is bits 7:0. A tick in the same cycle is discarded.
- R4: A read with `rd_sel` = 0 returns the holding copy. The holding copy takes the live count on each `snap_req` cycle and does not change at any other time.
- R5: While `line_in` is low, the block counts ticks. On the DISC_SECS-th such tick, the live count from before that tick is written into the disconnect timestamp (`rd_sel` = 1). This happens only once per low period. A high level on `line_in` restarts the tick count.
- R6: Sleep rises at the same edge as the disconnect capture, unless `no_sleep_strap` is high, in which case sleep stays low. Sleep falls at the first clock edge that sees `line_in` high after being low.
- R7: When `chg_pos` goes from 1 to 0, the live count of that cycle is written into the end-of-charge timestamp (`rd_sel` = 2). A rising `chg_pos` captures nothing.
- R8: Host writes with `wr_sel` = 1 or 2 replace one byte of the matching timestamp. If a capture lands in the same cycle, the capture wins.
- R9: The count keeps advancing while sleep is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| line_in | input | 1 | Sampled level of the bus line (idle high) |
| no_sleep_strap | input | 1 | When high, sleep is never raised |
| chg_pos | input | 1 | High while measured current is positive (charging) |
| snap_req | input | 1 | Copy live count into the holding copy |
| wr_en | input | 1 | Host byte write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 disconnect stamp, 2 end-of-charge stamp |
| wr_byte | input | BW | Byte index within the target word |
| wr_data | input | 8 | Byte written |
| rd_sel | input | 2 | Read source: 0 holding copy, 1 disconnect stamp, 2 end-of-charge stamp |
| rd_byte | input | BW | Byte index within the read word |
| rd_data | output | 8 | Selected byte (combinational) |
| sleep | output | 1 | Sleep indication after a disconnect |

## Verification
The bench builds the block with CNT_W = 16 and DISC_SECS = 2. A 16-bit count lets the bench tick through the full range and past the wrap within the cycle budget, sampling the holding copy at every 4096 seconds. A two-second disconnect window makes it quick to cover several cases: a low period cut short by a high pulse, the exact firing tick, repeated ticks after firing, and the strapped variant. Byte writes are swept over many values against an arithmetic model, and each capture is lined up in the same cycle as a host write to confirm that the capture wins.

// File: rtl/ptk_pkg.sv
package ptk_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_DISC  = 2'd1,
        SEL_EOC   = 2'd2,
        SEL_NONE  = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic                 en;
        word_sel_e            sel;
        logic [BYTE_BITS-1:0] data;
    } host_wr_t;

    function automatic logic [BYTE_BITS-1:0] pick_byte(input logic [63:0] w,
                                                       input int unsigned idx);
        return w[idx*BYTE_BITS +: BYTE_BITS];
    endfunction

endpackage

// File: rtl/ptk_counter.sv
module ptk_counter #(
    parameter int CNT_W = 32,
    localparam int NBYTES = CNT_W / 8,
    localparam int BW = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_tick,
    input  logic             wr_hit,
    input  logic [BW-1:0]    wr_byte,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_hit) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_byte == BW'(b)) cnt[b*8 +: 8] <= wr_data;
            end
        end else if (sec_tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ptk_word.sv
module ptk_word #(
    parameter int W = 32,
    localparam int NBYTES = W / 8,
    localparam int BW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [W-1:0]  cap_val,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_byte,
    input  logic [7:0]    wr_data,
    output logic [W-1:0]  q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cap) begin
            q <= cap_val;
        end else if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_byte == BW'(b)) q[b*8 +: 8] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/ptk_disconnect.sv
module ptk_disconnect #(
    parameter int DISC_SECS = 2,
    localparam int LW = $clog2(DISC_SECS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    input  logic line_in,
    input  logic no_sleep_strap,
    output logic disc_fire,
    output logic sleep
);

    logic [LW-1:0] low_cnt;
    logic          fired;
    logic          line_q;
    logic          line_rise;

    assign line_rise = line_in && !line_q;
    assign disc_fire = !line_in && sec_tick && !fired &&
                       (low_cnt == LW'(DISC_SECS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            fired   <= 1'b0;
            line_q  <= 1'b1;
        end else begin
            line_q <= line_in;
            if (line_in) begin
                low_cnt <= '0;
                fired   <= 1'b0;
            end else begin
                if (sec_tick && low_cnt != LW'(DISC_SECS)) low_cnt <= low_cnt + LW'(1);
                if (disc_fire) fired <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep <= 1'b0;
        end else if (disc_fire && !no_sleep_strap) begin
            sleep <= 1'b1;
        end else if (line_rise) begin
            sleep <= 1'b0;
        end
    end

endmodule

// File: rtl/pack_timekeeper.sv
module pack_timekeeper
    import ptk_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DISC_SECS = 2,
    localparam int NBYTES = CNT_W / 8,
    localparam int BW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sec_tick,
    input  logic          line_in,
    input  logic          no_sleep_strap,
    input  logic          chg_pos,
    input  logic          snap_req,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [BW-1:0] wr_byte,
    input  logic [7:0]    wr_data,
    input  logic [1:0]    rd_sel,
    input  logic [BW-1:0] rd_byte,
    output logic [7:0]    rd_data,
    output logic          sleep
);

    host_wr_t         hw;
    logic [CNT_W-1:0] cnt_live;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] stamp_q [2];
    logic [1:0]       stamp_cap;
    logic [1:0]       stamp_wr;
    logic             disc_fire;
    logic             chg_q;
    logic             eoc_evt;

    assign hw.en   = wr_en;
    assign hw.sel  = word_sel_e'(wr_sel);
    assign hw.data = wr_data;

    ptk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .wr_hit   (hw.en && hw.sel == SEL_COUNT),
        .wr_byte  (wr_byte),
        .wr_data  (hw.data),
        .cnt      (cnt_live)
    );

    always_ff @(posedge clk) begin
        if (rst)           hold_q <= '0;
        else if (snap_req) hold_q <= cnt_live;
    end

    ptk_disconnect #(.DISC_SECS(DISC_SECS)) u_disc (
        .clk            (clk),
        .rst            (rst),
        .sec_tick       (sec_tick),
        .line_in        (line_in),
        .no_sleep_strap (no_sleep_strap),
        .disc_fire      (disc_fire),
        .sleep          (sleep)
    );

    always_ff @(posedge clk) begin
        if (rst) chg_q <= 1'b0;
        else     chg_q <= chg_pos;
    end
    assign eoc_evt = chg_q && !chg_pos;

    assign stamp_cap   = {eoc_evt, disc_fire};
    assign stamp_wr[0] = hw.en && hw.sel == SEL_DISC;
    assign stamp_wr[1] = hw.en && hw.sel == SEL_EOC;

    for (genvar g = 0; g < 2; g++) begin : g_stamp
        ptk_word #(.W(CNT_W)) u_word (
            .clk     (clk),
            .rst     (rst),
            .cap     (stamp_cap[g]),
            .cap_val (cnt_live),
            .wr_en   (stamp_wr[g]),
            .wr_byte (wr_byte),
            .wr_data (hw.data),
            .q       (stamp_q[g])
        );
    end

    always_comb begin
        case (word_sel_e'(rd_sel))
            SEL_COUNT: rd_data = pick_byte(64'(hold_q), 32'(rd_byte));
            SEL_DISC:  rd_data = pick_byte(64'(stamp_q[0]), 32'(rd_byte));
            SEL_EOC:   rd_data = pick_byte(64'(stamp_q[1]), 32'(rd_byte));
            default:   rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/ptk_chk.sv
module ptk_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             sec_tick,
    input logic             line_in,
    input logic             no_sleep_strap,
    input logic             chg_pos,
    input logic             snap_req,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             sleep,
    input logic [CNT_W-1:0] cnt_live,
    input logic [CNT_W-1:0] hold_q,
    input logic [CNT_W-1:0] disc_q,
    input logic [CNT_W-1:0] eoc_q
);

    // R1
    reset_sleep_chk: assert property (@(posedge clk) rst |=> !sleep);

    // R2
    tick_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !(wr_en && wr_sel == 2'd0)) |=> cnt_live == CNT_W'($past(cnt_live) + 1));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !snap_req |=> $stable(hold_q));

    // R5
    disc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (line_in && !(wr_en && wr_sel == 2'd1)) |=> $stable(disc_q));

    // R6
    strap_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep && no_sleep_strap) |=> !sleep);

    // R6
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep && line_in) |=> !sleep);

    // R7
    eoc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (chg_pos && !(wr_en && wr_sel == 2'd2)) |=> $stable(eoc_q));

endmodule

bind pack_timekeeper ptk_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .sec_tick       (sec_tick),
    .line_in        (line_in),
    .no_sleep_strap (no_sleep_strap),
    .chg_pos        (chg_pos),
    .snap_req       (snap_req),
    .wr_en          (wr_en),
    .wr_sel         (wr_sel),
    .sleep          (sleep),
    .cnt_live       (cnt_live),
    .hold_q         (hold_q),
    .disc_q         (stamp_q[0]),
    .eoc_q          (stamp_q[1])
);

// File: tb/pack_timekeeper_test.sv
`timescale 1ns/100ps
module pack_timekeeper_test;

    localparam int CW = 16;
    localparam int NB = CW / 8;
    localparam int BW = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sec_tick = 1'b0;
    logic          line_in = 1'b1;
    logic          no_sleep_strap = 1'b0;
    logic          chg_pos = 1'b0;
    logic          snap_req = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [BW-1:0] wr_byte = '0;
    logic [7:0]    wr_data = 8'h00;
    logic [1:0]    rd_sel = 2'd0;
    logic [BW-1:0] rd_byte = '0;
    logic [7:0]    rd_data;
    logic          sleep;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [CW-1:0] model = '0;

    always #2 clk = ~clk;

    pack_timekeeper #(.CNT_W(CW), .DISC_SECS(2)) uut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .line_in(line_in),
        .no_sleep_strap(no_sleep_strap), .chg_pos(chg_pos), .snap_req(snap_req),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_byte(rd_byte), .rd_data(rd_data), .sleep(sleep)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_word(input logic [1:0] sel, output logic [31:0] v);
        v = '0;
        for (int b = 0; b < NB; b++) begin
            rd_sel = sel;
            rd_byte = BW'(b);
            #0.1;
            v[b*8 +: 8] = rd_data;
        end
    endtask

    task automatic tick(input int n);
        sec_tick = 1'b1;
        repeat (n) cyc();
        sec_tick = 1'b0;
        model = model + CW'(n);
    endtask

    task automatic snap();
        snap_req = 1'b1;
        cyc();
        snap_req = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input int b, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_byte = BW'(b); wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic set_count(input logic [CW-1:0] v);
        for (int b = 0; b < NB; b++) wr(2'd0, b, v[b*8 +: 8]);
        model = v;
    endtask

    initial begin
        logic [31:0] v;
        logic [CW-1:0] exp_stamp;
        cyc(); cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state
        rd_word(2'd0, v); check("R1 count", v, 0);
        rd_word(2'd1, v); check("R1 disc stamp", v, 0);
        rd_word(2'd2, v); check("R1 eoc stamp", v, 0);
        check("R1 sleep", 32'(sleep), 0);

        // R3 byte writes, tick in same cycle discarded
        sec_tick = 1'b1; wr(2'd0, 0, 8'h34); wr(2'd0, 1, 8'h12); sec_tick = 1'b0;
        model = 16'h1234;
        snap(); rd_word(2'd0, v); check("R3 write overrides tick", v, 32'h1234);
        tick(1); snap(); rd_word(2'd0, v); check("R2 tick after write", v, 32'(model));

        // R3 sweep of high-byte values
        for (int k = 0; k < 256; k += 17) begin
            wr(2'd0, 1, 8'(k));
            model[15:8] = 8'(k);
            snap(); rd_word(2'd0, v); check("R3 byte sweep", v, 32'(model));
        end

        // R4 holding copy stable without strobe
        snap(); rd_word(2'd0, v);
        exp_stamp = model;
        tick(50);
        rd_word(2'd0, v); check("R4 hold stable", v, 32'(exp_stamp));
        snap(); rd_word(2'd0, v); check("R4 hold refreshed", v, 32'(model));

        // R2 wrap
        set_count(16'hFFFE); tick(3); snap(); rd_word(2'd0, v);
        check("R2 wrap", v, 32'h0001);

        // R2 full-range sweep
        set_count(16'h0000);
        for (int s = 0; s < 17; s++) begin
            tick(4096); snap(); rd_word(2'd0, v);
            check("R2 sweep", v, 32'(model));
        end

        // R5 disconnect: interrupted low period, then firing
        set_count(16'h0100);
        line_in = 1'b0; tick(1);
        line_in = 1'b1; cyc();
        line_in = 1'b0; tick(1);
        rd_word(2'd1, v); check("R5 no early capture", v, 0);
        check("R6 no early sleep", 32'(sleep), 0);
        exp_stamp = model;
        tick(1);
        rd_word(2'd1, v); check("R5 disc capture", v, 32'(exp_stamp));
        check("R6 sleep raised", 32'(sleep), 1);
        tick(3);
        rd_word(2'd1, v); check("R5 capture once", v, 32'(exp_stamp));
        snap(); rd_word(2'd0, v); check("R9 counting in sleep", v, 32'(model));
        check("R6 sleep held while low", 32'(sleep), 1);
        line_in = 1'b1; cyc();
        check("R6 wake on rise", 32'(sleep), 0);

        // R6 strap suppresses sleep, capture still taken
        no_sleep_strap = 1'b1;
        line_in = 1'b0; tick(1);
        exp_stamp = model; tick(1);
        rd_word(2'd1, v); check("R5 strapped capture", v, 32'(exp_stamp));
        check("R6 strap no sleep", 32'(sleep), 0);
        line_in = 1'b1; no_sleep_strap = 1'b0; cyc();

        // R8 timestamp writes
        wr(2'd1, 0, 8'hEF); wr(2'd1, 1, 8'hBE);
        rd_word(2'd1, v); check("R8 disc write", v, 32'hBEEF);
        wr(2'd2, 1, 8'h5A);
        rd_word(2'd2, v); check("R8 eoc byte write", v, 32'h5A00);

        // R7 end-of-charge capture; rising edge captures nothing
        chg_pos = 1'b1; cyc();
        rd_word(2'd2, v); check("R7 rise no capture", v, 32'h5A00);
        tick(5);
        exp_stamp = model;
        chg_pos = 1'b0; cyc();
        rd_word(2'd2, v); check("R7 eoc capture", v, 32'(exp_stamp));

        // R8 capture wins over same-cycle write
        chg_pos = 1'b1; tick(2);
        exp_stamp = model;
        chg_pos = 1'b0; wr(2'd2, 0, 8'hAA);
        rd_word(2'd2, v); check("R8 capture beats write", v, 32'(exp_stamp));

        line_in = 1'b0; tick(1);
        exp_stamp = model;
        wr_en = 1'b1; wr_sel = 2'd1; wr_byte = '0; wr_data = 8'h77; sec_tick = 1'b1;
        cyc();
        wr_en = 1'b0; sec_tick = 1'b0; model = model + 1;
        rd_word(2'd1, v); check("R8 disc capture beats write", v, 32'(exp_stamp));
        line_in = 1'b1; cyc();

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule